// File: doc/BRIEF.md
# Byte-Serial Log/Antilog Column Mixer

This block applies the AES column-mixing step, or its inverse, to a 128-bit state. It forms one field product per clock. A product takes the logarithm of the data byte from a 256-entry table, adds the fixed logarithm of the coefficient modulo 255, and reads the result from a 256-entry antilogarithm table. Both tables are generated inside the design when it is elaborated. The products for each output byte are combined with XOR. Finished bytes are collected in a working register. The output register is loaded only after all 64 products are done, and a one-cycle done strobe marks that load.

The state is taken as 16 bytes. Byte 0 is bits [127:120] and byte 15 is bits [7:0]. Byte index k = 4*column + row, so the bytes fill the state column by column. A start strobe loads the state and the mode. A start that arrives while the engine is working is dropped.

The controller has three states: IDLE, RUN and PUBLISH. IDLE goes to RUN when start is seen (the "launch" transition). RUN stays in RUN until the 64th product (the "last product" transition) and then goes to PUBLISH. PUBLISH always goes back to IDLE on the next clock (the "release" transition). That clock loads the output register and raises done.

Top module: `mixcol_serial_engine`

## Requirements
- R1: During and right after reset, busy_o = 0, done_o = 0 and state_o = 0.
- R2: With mode_inv_i = 0, output row r of column c is the XOR over j = 0..3 of F[(j - r) mod 4] times input byte (c, j). F = {02, 03, 01, 01}, and the products are taken in GF(2^8) with modulus polynomial 0x11B.
- R3: With mode_inv_i = 1, the same rule applies with coefficients {0E, 0B, 0D, 09}.
- R4: Running the inverse mode on a forward-mode result gives back the original state.
- R5: A zero data byte adds nothing to its sum, and an all-zero state gives an all-zero result.
- R6: done_o is high for exactly one cycle, 65 clock edges after the edge that accepts start.
- R7: state_o keeps its earlier value for the whole operation and changes only in the cycle where done_o goes high.
- R8: A start pulse while busy_o = 1 is ignored. The state and mode it carries have no effect on the result.
- R9: busy_o goes high on the edge that accepts start and stays high until the edge that raises done_o, where it drops.
- R10: The mode is sampled when start is accepted. Changing mode_inv_i during an operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load state_i and mode_inv_i and begin an operation (ignored while busy) |
| mode_inv_i | input | 1 | 0 selects forward coefficients, 1 selects inverse coefficients |
| state_i | input | 128 | Input state, byte 0 in the top bits |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle strobe: state_o has just been updated |
| state_o | output | 128 | Registered result |

## Verification
The bench drives start just after a falling edge. The rising edge that follows accepts it. The result and done_o are due 65 rising edges later. The bench counts falling edges after the accepting edge and requires done_o to appear at count 65 exactly. At that point it compares state_o with a reference built from a shift-and-XOR field multiply. It samples state_o midway through a run, before done is due, to confirm that the old result is still held. The dropped-start and mode-change checks are made on the value released at count 65.

// File: rtl/mixcol_pkg.sv
package mixcol_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned N_ROWS   = 4;
    localparam int unsigned N_COLS   = 4;
    localparam int unsigned N_BYTES  = N_ROWS * N_COLS;
    localparam int unsigned STATE_W  = BYTE_W * N_BYTES;
    localparam int unsigned N_PROD   = N_BYTES * N_ROWS;
    localparam int unsigned CNT_W    = $clog2(N_PROD);
    localparam int unsigned ROW_W    = $clog2(N_ROWS);
    localparam int unsigned COL_W    = $clog2(N_COLS);
    localparam int unsigned IDX_W    = $clog2(N_BYTES);
    localparam int unsigned TBL_N    = 1 << BYTE_W;
    localparam int unsigned ORDER    = TBL_N - 1;
    localparam logic [BYTE_W-1:0] POLY_LO = 8'h1b;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUN     = 2'd1,
        ST_PUBLISH = 2'd2
    } mc_state_e;

    // multiply by x in the field
    function automatic logic [BYTE_W-1:0] gf_xtime(input logic [BYTE_W-1:0] v);
        return {v[BYTE_W-2:0], 1'b0} ^ (v[BYTE_W-1] ? POLY_LO : '0);
    endfunction

    // generator 03 raised to e
    function automatic logic [BYTE_W-1:0] gf_pow_f(input int unsigned e);
        logic [BYTE_W-1:0] p;
        p = 8'h01;
        for (int unsigned i = 0; i < e; i++) begin
            p = p ^ gf_xtime(p);
        end
        return p;
    endfunction

    // discrete log base 03; zero maps to zero (never used)
    function automatic logic [BYTE_W-1:0] gf_log_f(input logic [BYTE_W-1:0] x);
        logic [BYTE_W-1:0] p;
        logic [BYTE_W-1:0] r;
        p = 8'h01;
        r = '0;
        for (int e = 0; e < int'(ORDER); e++) begin
            if (p == x) r = BYTE_W'(e);
            p = p ^ gf_xtime(p);
        end
        return r;
    endfunction

    // circulant coefficient k of the selected direction
    function automatic logic [BYTE_W-1:0] mix_coef_f(input logic inv, input logic [ROW_W-1:0] k);
        logic [BYTE_W-1:0] c;
        if (!inv) begin
            case (k)
                2'd0:    c = 8'h02;
                2'd1:    c = 8'h03;
                default: c = 8'h01;
            endcase
        end else begin
            case (k)
                2'd0:    c = 8'h0e;
                2'd1:    c = 8'h0b;
                2'd2:    c = 8'h0d;
                default: c = 8'h09;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/gf_log_rom.sv
module gf_log_rom
    import mixcol_pkg::*;
(
    input  logic [BYTE_W-1:0] addr_i,
    output logic [BYTE_W-1:0] data_o
);
    logic [BYTE_W-1:0] rom [TBL_N];

    for (genvar g = 0; g < int'(TBL_N); g++) begin : g_ent
        localparam logic [BYTE_W-1:0] ENT = gf_log_f(BYTE_W'(g));
        assign rom[g] = ENT;
    end

    assign data_o = rom[addr_i];
endmodule

// File: rtl/gf_alog_rom.sv
module gf_alog_rom
    import mixcol_pkg::*;
(
    input  logic [BYTE_W-1:0] addr_i,
    output logic [BYTE_W-1:0] data_o
);
    logic [BYTE_W-1:0] rom [TBL_N];

    for (genvar g = 0; g < int'(TBL_N); g++) begin : g_ent
        localparam logic [BYTE_W-1:0] ENT = gf_pow_f(g);
        assign rom[g] = ENT;
    end

    assign data_o = rom[addr_i];
endmodule

// File: rtl/gf_logmul.sv
module gf_logmul
    import mixcol_pkg::*;
(
    input  logic [BYTE_W-1:0] data_i,
    input  logic [BYTE_W-1:0] coef_i,
    input  logic [BYTE_W-1:0] coef_log_i,
    output logic [BYTE_W-1:0] prod_o
);
    logic [BYTE_W-1:0] data_log;
    logic [BYTE_W:0]   log_sum;
    logic [BYTE_W-1:0] log_red;
    logic [BYTE_W-1:0] alog_val;

    gf_log_rom u_log (
        .addr_i (data_i),
        .data_o (data_log)
    );

    always_comb begin
        log_sum = {1'b0, data_log} + {1'b0, coef_log_i};
        if (log_sum >= (BYTE_W+1)'(ORDER)) begin
            log_red = BYTE_W'(log_sum - (BYTE_W+1)'(ORDER));
        end else begin
            log_red = log_sum[BYTE_W-1:0];
        end
    end

    gf_alog_rom u_alog (
        .addr_i (log_red),
        .data_o (alog_val)
    );

    always_comb begin
        if (data_i == '0) begin
            prod_o = '0;
        end else if (coef_i == 8'h01) begin
            prod_o = data_i;
        end else begin
            prod_o = alog_val;
        end
    end
endmodule

// File: rtl/mixcol_serial_engine.sv
module mixcol_serial_engine
    import mixcol_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic               mode_inv_i,
    input  logic [STATE_W-1:0] state_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [STATE_W-1:0] state_o
);
    mc_state_e st_q, st_d;

    logic [STATE_W-1:0] src_q;
    logic [STATE_W-1:0] work_q;
    logic               inv_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [BYTE_W-1:0]  acc_q;

    logic [COL_W-1:0]   col;
    logic [ROW_W-1:0]   row;
    logic [ROW_W-1:0]   term;
    logic [ROW_W-1:0]   k_sel;
    logic [IDX_W-1:0]   src_idx;
    logic [IDX_W-1:0]   dst_idx;
    logic [BYTE_W-1:0]  src_byte;
    logic [BYTE_W-1:0]  coef;
    logic [BYTE_W-1:0]  coef_log;
    logic [BYTE_W-1:0]  prod;
    logic               last_term;
    logic               last_prod;

    // coefficient logarithms, fixed at elaboration
    logic [BYTE_W-1:0] clog_tab [2][N_ROWS];
    for (genvar m = 0; m < 2; m++) begin : g_mode
        for (genvar k = 0; k < int'(N_ROWS); k++) begin : g_k
            localparam logic [BYTE_W-1:0] CL = gf_log_f(mix_coef_f(m[0], ROW_W'(k)));
            assign clog_tab[m][k] = CL;
        end
    end

    // iteration decode: column, output row, input term
    assign col       = cnt_q[CNT_W-1 -: COL_W];
    assign row       = cnt_q[ROW_W +: ROW_W];
    assign term      = cnt_q[ROW_W-1:0];
    assign k_sel     = term - row;
    assign src_idx   = {col, term};
    assign dst_idx   = {col, row};
    assign last_term = (term == ROW_W'(N_ROWS - 1));
    assign last_prod = (cnt_q == CNT_W'(N_PROD - 1));

    assign src_byte  = src_q[STATE_W-1-BYTE_W*int'(src_idx) -: BYTE_W];
    assign coef      = mix_coef_f(inv_q, k_sel);
    assign coef_log  = clog_tab[inv_q][k_sel];

    gf_logmul u_mul (
        .data_i     (src_byte),
        .coef_i     (coef),
        .coef_log_i (coef_log),
        .prod_o     (prod)
    );

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: launch, last product, release
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (start_i) st_d = ST_RUN;
            ST_RUN:     if (last_prod) st_d = ST_PUBLISH;
            ST_PUBLISH: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            src_q  <= '0;
            work_q <= '0;
            inv_q  <= 1'b0;
            cnt_q  <= '0;
            acc_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        src_q <= state_i;
                        inv_q <= mode_inv_i;
                        cnt_q <= '0;
                        acc_q <= '0;
                    end
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (term == '0) begin
                        acc_q <= prod;
                    end else begin
                        acc_q <= acc_q ^ prod;
                    end
                    if (last_term) begin
                        work_q[STATE_W-1-BYTE_W*int'(dst_idx) -: BYTE_W] <= acc_q ^ prod;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_o <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (st_q == ST_PUBLISH) begin
                state_o <= work_q;
                done_o  <= 1'b1;
            end
        end
    end

    assign busy_o = (st_q != ST_IDLE);

endmodule

// File: rtl/mixcol_serial_engine_chk.sv
module mixcol_serial_engine_chk
    import mixcol_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic               start_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [STATE_W-1:0] state_o
);
    localparam int unsigned LAT = N_PROD + 1;

    logic [CNT_W+1:0] busy_cnt;
    always_ff @(posedge clk_i) begin
        if (!rst_ni || !busy_o) busy_cnt <= '0;
        else                    busy_cnt <= busy_cnt + 1'b1;
    end

    a_r9_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> busy_o);

    a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o);

    a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (busy_cnt == (CNT_W+2)'(LAT)));

    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(state_o));

    a_r6_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);
endmodule

bind mixcol_serial_engine mixcol_serial_engine_chk chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .state_o (state_o)
);

// File: tb/mixcol_serial_engine_tb_top.sv
`timescale 1ns/1ps
module mixcol_serial_engine_tb_top;
    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic         start_i = 1'b0;
    logic         mode_inv_i = 1'b0;
    logic [127:0] state_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [127:0] state_o;

    int total = 0;
    int bad = 0;
    logic [127:0] last_out;

    always #2 clk_i = ~clk_i;

    mixcol_serial_engine dut_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start_i),
        .mode_inv_i (mode_inv_i),
        .state_i    (state_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .state_o    (state_o)
    );

    function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r = r ^ x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
        end
        return r;
    endfunction

    function automatic logic [7:0] cf(input logic inv, input int k);
        logic [7:0] f [4] = '{8'h02, 8'h03, 8'h01, 8'h01};
        logic [7:0] v [4] = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
        return inv ? v[k] : f[k];
    endfunction

    function automatic logic [127:0] ref_mix(input logic [127:0] s, input logic inv);
        logic [127:0] o = '0;
        for (int c = 0; c < 4; c++) begin
            for (int r = 0; r < 4; r++) begin
                logic [7:0] acc = 0;
                for (int j = 0; j < 4; j++) begin
                    acc = acc ^ gm(s[127-8*(4*c+j) -: 8], cf(inv, (j - r + 4) % 4));
                end
                o[127-8*(4*c+r) -: 8] = acc;
            end
        end
        return o;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // runs one operation; optional mid-run disturbance; checks latency and hold
    task automatic run_op(input string req, input logic [127:0] s, input logic inv,
                          input bit disturb, output logic [127:0] res);
        int n = 0;
        @(negedge clk_i);
        state_i = s; mode_inv_i = inv; start_i = 1'b1;
        @(posedge clk_i);
        @(negedge clk_i);
        start_i = 1'b0;
        check({req, " R9 busy after launch"}, 128'(busy_o), 128'd1);
        while (n < 200) begin
            @(posedge clk_i);
            @(negedge clk_i);
            n++;
            if (n == 30) begin
                check({req, " R7 output held"}, state_o, last_out);
                if (disturb) begin
                    start_i = 1'b1; state_i = ~s; mode_inv_i = ~inv;
                end
            end
            if (n == 31) begin
                start_i = 1'b0;
                mode_inv_i = inv;
            end
            if (done_o) break;
        end
        check({req, " R6 latency"}, 128'(n), 128'd65);
        check({req, " R9 busy low at done"}, 128'(busy_o), 128'd0);
        res = state_o;
        @(posedge clk_i);
        @(negedge clk_i);
        check({req, " R6 single pulse"}, 128'(done_o), 128'd0);
        last_out = res;
    endtask

    task automatic t_reset();
        check("R1 busy", 128'(busy_o), 128'd0);
        check("R1 done", 128'(done_o), 128'd0);
        check("R1 state", state_o, 128'd0);
    endtask

    task automatic t_known();
        logic [127:0] s = 128'hdb135345_f20a225c_01010101_c6c6c6c6;
        logic [127:0] r;
        run_op("R2", s, 1'b0, 1'b0, r);
        check("R2 known vector", r, 128'h8e4da1bc_9fdc589d_01010101_c6c6c6c6);
    endtask

    task automatic t_forward();
        logic [127:0] pats [3] = '{128'h00112233_44556677_8899aabb_ccddeeff,
                                   128'h01000000_00010000_00000100_00000001,
                                   128'hffffffff_80808080_7f7f7f7f_a5c3e10f};
        logic [127:0] r;
        foreach (pats[i]) begin
            run_op("R2", pats[i], 1'b0, 1'b0, r);
            check("R2 forward pattern", r, ref_mix(pats[i], 1'b0));
        end
    endtask

    task automatic t_inverse();
        logic [127:0] s = 128'h3243f6a8_885a308d_313198a2_e0370734;
        logic [127:0] f, r;
        run_op("R3", s, 1'b1, 1'b0, r);
        check("R3 inverse pattern", r, ref_mix(s, 1'b1));
        run_op("R4", s, 1'b0, 1'b0, f);
        run_op("R4", f, 1'b1, 1'b0, r);
        check("R4 round trip", r, s);
    endtask

    task automatic t_zero();
        logic [127:0] s = 128'h00000000_00570000_00000000_13000000;
        logic [127:0] r;
        run_op("R5", '0, 1'b0, 1'b0, r);
        check("R5 all zero", r, '0);
        run_op("R5", s, 1'b1, 1'b0, r);
        check("R5 sparse zeros", r, ref_mix(s, 1'b1));
    endtask

    task automatic t_disturb();
        logic [127:0] s = 128'hd4bf5d30_e0b452ae_b84111f1_1e2798e5;
        logic [127:0] r;
        run_op("R8", s, 1'b0, 1'b1, r);
        check("R8 start ignored while busy", r, ref_mix(s, 1'b0));
        run_op("R10", s, 1'b1, 1'b1, r);
        check("R10 mode latched", r, ref_mix(s, 1'b1));
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        last_out = '0;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_known();
        t_forward();
        t_inverse();
        t_zero();
        t_disturb();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule